// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two W-bit data ports, called A and B. Each direction of transfer has its own storage element and its own three active-low controls: a select, a gate and a drive enable. Data flowing from A towards B is held in the A-to-B store and presented on the B side. The opposite direction works the same way with a separate store and a separate control set. Each port is modelled as an input vector with a "driven" qualifier, plus an output vector and a one-bit output enable. A real tri-state pad can therefore be built around the block outside it.

The latch is emulated inside one clock domain. The effective gate of a direction is the OR of its select and gate inputs. While that gate is low, the store loads the incoming port value on every clock. The clock edge at which the gate is first seen high captures the value present in that cycle. After that, the store holds. A drive enable is registered from the select and drive-enable inputs. Each port has a bus-hold register that remembers the last driven value. A flag reports when both directions drive at once.

Top module: `xlp_xcvr`

## Requirements
- R1: After reset, both stores read 0, `a_oe`, `b_oe` and `contention` are 0, and both bus-hold registers hold 0.
- R2: When `ab_sel_n` and `ab_gate_n` are both 0 at a clock edge, `b_out` shows after that edge the A value sampled at that edge.
- R3: Suppose the A-to-B gate (`ab_sel_n` OR `ab_gate_n`) was low at the previous edge and `ab_gate_n` is 1 at this edge. Then the A value sampled at this edge is captured, and later A changes do not alter `b_out`.
- R4: A rise of `ab_sel_n` while `ab_gate_n` is 0 captures data in the same way as R3.
- R5: When the A-to-B gate is high at two consecutive edges, `b_out` is unchanged after the second edge.
- R6: After an edge, `b_oe` is 1 exactly when `ab_sel_n` and `ab_oe_n` were both 0 at that edge; if either was 1, `b_oe` is 0. `b_out` always shows the A-to-B store.
- R7: While `ab_sel_n` is 1, toggling `ab_gate_n` or changing A data (after the closing edge) leaves `b_out` unchanged.
- R8: The B-to-A direction behaves like R2 to R7 with `ba_sel_n`, `ba_gate_n`, `ba_oe_n`, `b_in`, `a_out` and `a_oe`, and it is fully independent of the A-to-B direction.
- R9: When `a_in_drv` is 0, the A-to-B store loads the last value seen while `a_in_drv` was 1 instead of `a_in`. `b_in_drv` works the same way for the other direction.
- R10: `contention` is 1 in a cycle exactly when `a_oe` and `b_oe` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | W | Value observed on port A |
| a_in_drv | input | 1 | 1 when port A is actively driven from outside |
| b_in | input | W | Value observed on port B |
| b_in_drv | input | 1 | 1 when port B is actively driven from outside |
| ab_sel_n | input | 1 | A-to-B select, active low |
| ab_gate_n | input | 1 | A-to-B latch gate, active low |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_sel_n | input | 1 | B-to-A select, active low |
| ba_gate_n | input | 1 | B-to-A latch gate, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | W | B-to-A store contents for port A |
| a_oe | output | 1 | Drive enable for port A |
| b_out | output | W | A-to-B store contents for port B |
| b_oe | output | 1 | Drive enable for port B |
| contention | output | 1 | Both ports driven by the block at once |

## Verification
Two functions can fall in the same clock edge: the closing capture and a data change. The bench raises the gate, or the select, in the same cycle that it places a new A value. It then checks that this new value, and not the earlier one, is the one held. It also changes A data in the following cycles and judges that `b_out` stays frozen. A second collision is a capture in one direction while the other direction is transparent. This is provoked by running B-to-A transfers while the A-to-B store holds, and it is judged by confirming that neither store moves from the other's activity.

// File: rtl/xlp_pkg.sv
package xlp_pkg;

    // Active-low control set for one transfer direction
    typedef struct packed {
        logic sel_n;
        logic gate_n;
        logic oe_n;
    } xlp_ctrl_t;

endpackage

// File: rtl/xlp_hold.sv
module xlp_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         din_drv,
    output logic [W-1:0] dval
);

    logic [W-1:0] keep_d, keep_q;

    always_comb begin
        keep_d = keep_q;
        if (din_drv) begin
            keep_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else begin
            keep_q <= keep_d;
        end
    end

    // R9: an undriven port presents the last driven value
    assign dval = din_drv ? din : keep_q;

endmodule

// File: rtl/xlp_path.sv
module xlp_path
    import xlp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  xlp_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    input  logic         din_drv,
    output logic [W-1:0] dout,
    output logic         dout_en
);

    typedef struct packed {
        logic [W-1:0] store;
        logic         gate_n;
        logic         oe;
    } path_st_t;

    path_st_t     st_d, st_q;
    logic [W-1:0] dval;
    logic         gate_now_n;

    xlp_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .din_drv (din_drv),
        .dval    (dval)
    );

    // Effective gate: open only when select and gate are both low
    assign gate_now_n = ctrl.sel_n | ctrl.gate_n;

    always_comb begin
        st_d        = st_q;
        st_d.gate_n = gate_now_n;
        // Transparent (gate low) or closing edge (was low, now high)
        if (!gate_now_n || !st_q.gate_n) begin
            st_d.store = dval;
        end
        st_d.oe = !ctrl.sel_n && !ctrl.oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.store  <= '0;
            st_q.gate_n <= 1'b1;
            st_q.oe     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.store;
    assign dout_en = st_q.oe;

endmodule

// File: rtl/xlp_xcvr.sv
module xlp_xcvr
    import xlp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         a_in_drv,
    input  logic [W-1:0] b_in,
    input  logic         b_in_drv,
    input  logic         ab_sel_n,
    input  logic         ab_gate_n,
    input  logic         ab_oe_n,
    input  logic         ba_sel_n,
    input  logic         ba_gate_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         contention
);

    xlp_ctrl_t ab_ctrl, ba_ctrl;

    assign ab_ctrl = '{sel_n: ab_sel_n, gate_n: ab_gate_n, oe_n: ab_oe_n};
    assign ba_ctrl = '{sel_n: ba_sel_n, gate_n: ba_gate_n, oe_n: ba_oe_n};

    // A to B direction
    xlp_path #(.W(W)) u_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ab_ctrl),
        .din     (a_in),
        .din_drv (a_in_drv),
        .dout    (b_out),
        .dout_en (b_oe)
    );

    // B to A direction
    xlp_path #(.W(W)) u_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ba_ctrl),
        .din     (b_in),
        .din_drv (b_in_drv),
        .dout    (a_out),
        .dout_en (a_oe)
    );

    assign contention = a_oe & b_oe;

endmodule

// File: rtl/xlp_chk.sv
module xlp_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic         a_in_drv,
    input logic [W-1:0] b_in,
    input logic         b_in_drv,
    input logic         ab_sel_n,
    input logic         ab_gate_n,
    input logic         ab_oe_n,
    input logic         ba_sel_n,
    input logic         ba_gate_n,
    input logic         ba_oe_n,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         contention
);

    // R2
    ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_sel_n && !ab_gate_n && a_in_drv) |=> (b_out == $past(a_in)));

    // R5
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ab_sel_n || ab_gate_n) && $past(ab_sel_n || ab_gate_n)) |=> $stable(b_out));

    // R6
    ab_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_sel_n || ab_oe_n) |=> !b_oe);

    // R8
    ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_sel_n && !ba_gate_n && b_in_drv) |=> (a_out == $past(b_in)));

    // R8
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ba_sel_n || ba_gate_n) && $past(ba_sel_n || ba_gate_n)) |=> $stable(a_out));

    // R10
    contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_sel_n && !ab_oe_n && !ba_sel_n && !ba_oe_n) |=> contention);

endmodule

bind xlp_xcvr xlp_chk #(.W(W)) u_xlp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (a_in),
    .a_in_drv   (a_in_drv),
    .b_in       (b_in),
    .b_in_drv   (b_in_drv),
    .ab_sel_n   (ab_sel_n),
    .ab_gate_n  (ab_gate_n),
    .ab_oe_n    (ab_oe_n),
    .ba_sel_n   (ba_sel_n),
    .ba_gate_n  (ba_gate_n),
    .ba_oe_n    (ba_oe_n),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .contention (contention)
);

// File: tb/test_xlp_xcvr.sv
module test_xlp_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_in_drv = 1'b1, b_in_drv = 1'b1;
    logic         ab_sel_n = 1'b1, ab_gate_n = 1'b1, ab_oe_n = 1'b1;
    logic         ba_sel_n = 1'b1, ba_gate_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlp_xcvr #(.W(W)) i_xlp_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_in_drv(a_in_drv), .b_in(b_in), .b_in_drv(b_in_drv),
        .ab_sel_n(ab_sel_n), .ab_gate_n(ab_gate_n), .ab_oe_n(ab_oe_n),
        .ba_sel_n(ba_sel_n), .ba_gate_n(ba_gate_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .contention(contention)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge, then settle away from the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 b_out", b_out, 0);
        chk("R1 a_out", a_out, 0);
        chk("R1 b_oe", b_oe, 0);
        chk("R1 a_oe", a_oe, 0);
        chk("R1 contention", contention, 0);
    endtask

    task automatic t_transparent();
        ab_sel_n = 0; ab_gate_n = 0; ab_oe_n = 0; a_in = 8'h3C;
        tick();
        chk("R2 follow 3C", b_out, 8'h3C);
        chk("R6 b_oe on", b_oe, 1);
        a_in = 8'hA5;
        tick();
        chk("R2 follow A5", b_out, 8'hA5);
    endtask

    task automatic t_gate_capture();
        a_in = 8'h5A; ab_gate_n = 1;   // closing edge sees new data
        tick();
        chk("R3 capture 5A", b_out, 8'h5A);
        a_in = 8'hFF;
        tick();
        tick();
        chk("R5 held 5A", b_out, 8'h5A);
    endtask

    task automatic t_sel_capture();
        ab_gate_n = 0; ab_sel_n = 0; a_in = 8'h11;
        tick();
        chk("R2 follow 11", b_out, 8'h11);
        ab_sel_n = 1; a_in = 8'h22;
        tick();
        chk("R4 capture 22", b_out, 8'h22);
        chk("R6 b_oe off sel high", b_oe, 0);
        a_in = 8'h33; ab_gate_n = 1;
        tick();
        ab_gate_n = 0; a_in = 8'h44;
        tick();
        chk("R7 sel high ignores gate", b_out, 8'h22);
        ab_sel_n = 0; ab_gate_n = 1; ab_oe_n = 0;
        tick();
        chk("R5 hold after sel low", b_out, 8'h22);
        chk("R6 b_oe back on", b_oe, 1);
        ab_oe_n = 1;
        tick();
        chk("R6 b_oe off oe high", b_oe, 0);
        chk("R6 data kept", b_out, 8'h22);
    endtask

    task automatic t_reverse();
        ba_sel_n = 0; ba_gate_n = 0; ba_oe_n = 0; b_in = 8'h9E;
        tick();
        chk("R8 ba follow", a_out, 8'h9E);
        chk("R8 a_oe on", a_oe, 1);
        chk("R8 ab unaffected", b_out, 8'h22);
        b_in = 8'h61; ba_gate_n = 1;
        tick();
        b_in = 8'h00;
        tick();
        chk("R8 ba capture", a_out, 8'h61);
        ab_sel_n = 0; ab_gate_n = 0; a_in = 8'h7D;
        tick();
        chk("R8 ba kept while ab moves", a_out, 8'h61);
        chk("R8 ab moves", b_out, 8'h7D);
    endtask

    task automatic t_bus_hold();
        a_in_drv = 1; a_in = 8'h77;
        tick();
        a_in_drv = 0; a_in = 8'h00;
        tick();
        chk("R9 a bus hold", b_out, 8'h77);
        a_in_drv = 1; ab_gate_n = 1;
        ba_gate_n = 0; b_in_drv = 1; b_in = 8'hC3;
        tick();
        b_in_drv = 0; b_in = 8'h0F;
        tick();
        chk("R9 b bus hold", a_out, 8'hC3);
        b_in_drv = 1; ba_gate_n = 1;
    endtask

    task automatic t_contention();
        ab_sel_n = 0; ab_oe_n = 0; ba_sel_n = 0; ba_oe_n = 0;
        tick();
        chk("R10 both drive", contention, 1);
        ba_oe_n = 1;
        tick();
        chk("R10 one drives", contention, 0);
        chk("R10 b_oe still", b_oe, 1);
    endtask

    initial begin
        #1;
        tick();
        tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_transparent();
        t_gate_capture();
        t_sel_capture();
        t_reverse();
        t_bus_hold();
        t_contention();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule